// File: doc/BRIEF.md
# Low-Power Standby Wake Controller

This block sequences a microcontroller core into and out of a deep standby state. A sleep strobe taken while the standby-select bit is set moves the core into standby. In standby the oscillator and clock gates turn off and the external bus is released to high impedance. Internal state is kept, so leaving standby never issues a reset.

The block supports three ways out of standby. An interrupt wake (NMI, or a qualified IRQ line) restarts the oscillator at once but keeps the clocks gated for a settling interval chosen by a 3-bit code. When that interval ends, clocks return and a one-cycle interrupt-exception strobe goes out together with the latched wake cause. A low level on either reset input restarts the oscillator and supplies clocks in the same step, with no settling wait. A reset-exception strobe follows when both reset inputs are high again. A low hardware-standby pin overrides all of this and parks the block until its own asynchronous reset.

The oscillator, the CPU and register retention lie outside the block. They are represented only by the enable and strobe outputs.

Top module: `standby_wake_ctrl`

## Requirements
- R1: In the running state, a sleep strobe with `stby_sel`=1 enters standby: at the next clock `osc_en`=0, `clk_gate_en`=0 and `bus_hiz`=1. A sleep strobe with `stby_sel`=0 leaves the block running, with `clk_gate_en`=1 and `bus_hiz`=0.
- R2: While in standby, the oscillator and clock gates stay off, the bus stays in high impedance, and neither `wake_irq_stb` nor `reset_exc_stb` is asserted.
- R3: In standby, a wake request (NMI or a qualified IRQ) makes `osc_en`=1 at the next clock. `clk_gate_en` then stays 0 for exactly 2^(8+code) cycles, where code is the `settle_sel` value sampled with the wake request.
- R4: When the settling interval ends, `clk_gate_en` rises to 1 and `bus_hiz` falls to 0. In that same cycle `wake_irq_stb` is high for exactly one cycle.
- R5: IRQ line n can wake the block only when `irq_req[n]`=1, `irq_en[n]`=1, `irq_mask[n]`=0 and `irq_dma[n]`=0. Any other combination leaves `osc_en` at 0.
- R6: `wake_cause` is valid with `wake_irq_stb`. Its encoding is 4'b1000 for NMI and {1'b0, n} for IRQ n. NMI wins over any IRQ in the same cycle, and among IRQs the lowest index wins.
- R7: In standby, a low level on `res_n` or `mres_n` makes `osc_en`=1 and `clk_gate_en`=1 together at the next clock, with `bus_hiz`=0 and no settling wait. This reset path takes priority over an interrupt wake arriving in the same cycle.
- R8: After a reset wake, when `res_n` and `mres_n` are both high, the block returns to running and `reset_exc_stb` is high for exactly one cycle.
- R9: `hwstby_n`=0 moves the block from any state into hardware standby at the next clock: `hw_standby`=1, `osc_en`=0, `clk_gate_en`=0, `bus_hiz`=1. The state holds against every wake source until `rst_n` is asserted.
- R10: A sleep strobe that arrives during the settling interval or during the reset hold is ignored. The block then returns to running and stays there.
- R11: While and after `rst_n` is low, the block is running: `osc_en`=1, `clk_gate_en`=1, `bus_hiz`=0, `hw_standby`=0, and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset of the whole block |
| sleep_stb | input | 1 | One-cycle sleep-instruction strobe |
| stby_sel | input | 1 | Selects deep standby for a sleep strobe |
| settle_sel | input | 3 | Settling-time code, count is 2^(8+code) |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_req | input | 8 | IRQ request lines |
| irq_en | input | 8 | Per-line IRQ enable |
| irq_mask | input | 8 | Per-line CPU mask flag |
| irq_dma | input | 8 | Per-line flag: line activates a transfer, not the CPU |
| res_n | input | 1 | Active-low system reset input |
| mres_n | input | 1 | Active-low manual reset input |
| hwstby_n | input | 1 | Active-low hardware-standby pin |
| osc_en | output | 1 | Oscillator enable |
| clk_gate_en | output | 1 | Clock-gate enable for the core |
| bus_hiz | output | 1 | Address bus and bus-control outputs to high impedance |
| wake_irq_stb | output | 1 | One-cycle interrupt-exception start |
| wake_cause | output | 4 | Latched wake source, valid with wake_irq_stb |
| reset_exc_stb | output | 1 | One-cycle reset-exception start |
| hw_standby | output | 1 | Hardware-standby indication |

## Verification
The bound checker watches on every cycle that the enable outputs follow a sleep strobe, a qualified or unqualified wake request, or a reset level in the next cycle. It also checks that the two strobes last one cycle, never coincide, and appear only on the right transitions, and that hardware standby is entered and held. The exact settling length for different codes, the reported cause when several sources compete, and the fact that a strobe ignored during settling or reset hold leaves the block running all span many cycles. These are shown only by the bench scenarios, whose scoreboard pairs each expected wake or reset event with the observed strobe and the measured gated interval.

// File: rtl/swc_pkg.sv
package swc_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_STANDBY,
        ST_SETTLE,
        ST_RESET_HOLD,
        ST_HW_STANDBY
    } swc_state_e;
endpackage

// File: rtl/swc_wake_select.sv
module swc_wake_select #(
    parameter int N_IRQ = 8,
    localparam int IDX_W = $clog2(N_IRQ),
    localparam int CAUSE_W = IDX_W + 1
) (
    input  logic               nmi_req,
    input  logic [N_IRQ-1:0]   irq_req,
    input  logic [N_IRQ-1:0]   irq_en,
    input  logic [N_IRQ-1:0]   irq_mask,
    input  logic [N_IRQ-1:0]   irq_dma,
    output logic               wake_valid,
    output logic [CAUSE_W-1:0] wake_cause
);
    logic [N_IRQ-1:0] qual;
    logic [IDX_W-1:0] idx;

    // a line qualifies only if requested, enabled, not masked, not routed to a transfer
    for (genvar g = 0; g < N_IRQ; g++) begin : g_qual
        assign qual[g] = irq_req[g] & irq_en[g] & ~irq_mask[g] & ~irq_dma[g];
    end

    // lowest index wins among IRQ lines
    always_comb begin
        idx = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (qual[i]) idx = i[IDX_W-1:0];
        end
    end

    assign wake_valid = nmi_req | (|qual);
    assign wake_cause = nmi_req ? {1'b1, {IDX_W{1'b0}}} : {1'b0, idx};
endmodule

// File: rtl/swc_settle_timer.sv
module swc_settle_timer #(
    parameter int CODE_W = 3,
    parameter int BASE_LOG2 = 8,
    localparam int CNT_W = BASE_LOG2 + (1 << CODE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code,
    input  logic              dec,
    output logic              done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            // interval of 2^(BASE_LOG2+code) cycles: load one less, run down to zero
            cnt_d = ({{(CNT_W-1){1'b0}}, 1'b1} << (BASE_LOG2 + int'(code))) - {{(CNT_W-1){1'b0}}, 1'b1};
        end else if (dec && cnt_q != '0) begin
            cnt_d = cnt_q - {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl #(
    parameter int N_IRQ = 8,
    parameter int CODE_W = 3,
    parameter int BASE_LOG2 = 8,
    localparam int CAUSE_W = $clog2(N_IRQ) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_stb,
    input  logic               stby_sel,
    input  logic [CODE_W-1:0]  settle_sel,
    input  logic               nmi_req,
    input  logic [N_IRQ-1:0]   irq_req,
    input  logic [N_IRQ-1:0]   irq_en,
    input  logic [N_IRQ-1:0]   irq_mask,
    input  logic [N_IRQ-1:0]   irq_dma,
    input  logic               res_n,
    input  logic               mres_n,
    input  logic               hwstby_n,
    output logic               osc_en,
    output logic               clk_gate_en,
    output logic               bus_hiz,
    output logic               wake_irq_stb,
    output logic [CAUSE_W-1:0] wake_cause,
    output logic               reset_exc_stb,
    output logic               hw_standby
);
    import swc_pkg::*;

    typedef struct packed {
        swc_state_e         state;
        logic               wake_stb;
        logic               rst_stb;
        logic [CAUSE_W-1:0] cause;
    } swc_regs_t;

    swc_regs_t cur_q, nxt_d;

    logic               wake_valid;
    logic [CAUSE_W-1:0] sel_cause;
    logic               tmr_load, tmr_dec, tmr_done;
    logic               rst_req;
    swc_state_e         state_mon;

    swc_wake_select #(.N_IRQ(N_IRQ)) u_sel (
        .nmi_req    (nmi_req),
        .irq_req    (irq_req),
        .irq_en     (irq_en),
        .irq_mask   (irq_mask),
        .irq_dma    (irq_dma),
        .wake_valid (wake_valid),
        .wake_cause (sel_cause)
    );

    swc_settle_timer #(.CODE_W(CODE_W), .BASE_LOG2(BASE_LOG2)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .code  (settle_sel),
        .dec   (tmr_dec),
        .done  (tmr_done)
    );

    assign rst_req = ~res_n | ~mres_n;

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.wake_stb = 1'b0;
        nxt_d.rst_stb  = 1'b0;
        tmr_load       = 1'b0;
        tmr_dec        = 1'b0;
        if (!hwstby_n) begin
            nxt_d.state = ST_HW_STANDBY;
        end else begin
            case (cur_q.state)
                ST_RUN: begin
                    if (sleep_stb && stby_sel) nxt_d.state = ST_STANDBY;
                end
                ST_STANDBY: begin
                    if (rst_req) begin
                        nxt_d.state = ST_RESET_HOLD;
                    end else if (wake_valid) begin
                        nxt_d.state = ST_SETTLE;
                        nxt_d.cause = sel_cause;
                        tmr_load    = 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (tmr_done) begin
                        nxt_d.state    = ST_RUN;
                        nxt_d.wake_stb = 1'b1;
                    end else begin
                        tmr_dec = 1'b1;
                    end
                end
                ST_RESET_HOLD: begin
                    if (!rst_req) begin
                        nxt_d.state   = ST_RUN;
                        nxt_d.rst_stb = 1'b1;
                    end
                end
                ST_HW_STANDBY: nxt_d.state = ST_HW_STANDBY;
                default:       nxt_d.state = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_RUN, wake_stb: 1'b0, rst_stb: 1'b0, cause: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        osc_en      = 1'b1;
        clk_gate_en = 1'b1;
        bus_hiz     = 1'b0;
        hw_standby  = 1'b0;
        case (cur_q.state)
            ST_STANDBY: begin
                osc_en      = 1'b0;
                clk_gate_en = 1'b0;
                bus_hiz     = 1'b1;
            end
            ST_SETTLE: begin
                clk_gate_en = 1'b0;
                bus_hiz     = 1'b1;
            end
            ST_HW_STANDBY: begin
                osc_en      = 1'b0;
                clk_gate_en = 1'b0;
                bus_hiz     = 1'b1;
                hw_standby  = 1'b1;
            end
            default: ;
        endcase
    end

    assign wake_irq_stb  = cur_q.wake_stb;
    assign reset_exc_stb = cur_q.rst_stb;
    assign wake_cause    = cur_q.cause;
    assign state_mon     = cur_q.state;
endmodule

// File: rtl/swc_checks.sv
module swc_checks #(
    parameter int N_IRQ = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sleep_stb,
    input logic               stby_sel,
    input logic               nmi_req,
    input logic [N_IRQ-1:0]   irq_req,
    input logic [N_IRQ-1:0]   irq_en,
    input logic [N_IRQ-1:0]   irq_mask,
    input logic [N_IRQ-1:0]   irq_dma,
    input logic               res_n,
    input logic               mres_n,
    input logic               hwstby_n,
    input logic               osc_en,
    input logic               clk_gate_en,
    input logic               bus_hiz,
    input logic               wake_irq_stb,
    input logic               reset_exc_stb,
    input logic               hw_standby,
    input swc_pkg::swc_state_e state
);
    import swc_pkg::*;

    logic any_irq;
    assign any_irq = |(irq_req & irq_en & ~irq_mask & ~irq_dma);

    p_enter_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_stb && stby_sel && hwstby_n) |=> (!osc_en && !clk_gate_en && bus_hiz));

    p_stay_running_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_stb && !stby_sel && hwstby_n) |=> (clk_gate_en && !bus_hiz));

    p_standby_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STANDBY) |-> (!wake_irq_stb && !reset_exc_stb));

    p_irq_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STANDBY && hwstby_n && res_n && mres_n && (nmi_req || any_irq))
        |=> (osc_en && !clk_gate_en));

    p_wake_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq_stb |-> (clk_gate_en && !bus_hiz && $past(osc_en) && !$past(clk_gate_en)));

    p_wake_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq_stb |=> !wake_irq_stb);

    p_no_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STANDBY && hwstby_n && res_n && mres_n && !nmi_req && !any_irq) |=> !osc_en);

    p_reset_clocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STANDBY && hwstby_n && !(res_n && mres_n)) |=> (osc_en && clk_gate_en && !bus_hiz));

    p_reset_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_exc_stb |=> !reset_exc_stb);

    p_reset_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_exc_stb |-> ($past(state) == ST_RESET_HOLD));

    p_strobes_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wake_irq_stb, reset_exc_stb}));

    p_hw_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hwstby_n |=> (hw_standby && !osc_en && !clk_gate_en && bus_hiz));

    p_hw_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hw_standby |=> hw_standby);

    p_sleep_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SETTLE || state == ST_RESET_HOLD) && sleep_stb && hwstby_n) |=> (state != ST_STANDBY));
endmodule

bind standby_wake_ctrl swc_checks #(.N_IRQ(N_IRQ)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_stb     (sleep_stb),
    .stby_sel      (stby_sel),
    .nmi_req       (nmi_req),
    .irq_req       (irq_req),
    .irq_en        (irq_en),
    .irq_mask      (irq_mask),
    .irq_dma       (irq_dma),
    .res_n         (res_n),
    .mres_n        (mres_n),
    .hwstby_n      (hwstby_n),
    .osc_en        (osc_en),
    .clk_gate_en   (clk_gate_en),
    .bus_hiz       (bus_hiz),
    .wake_irq_stb  (wake_irq_stb),
    .reset_exc_stb (reset_exc_stb),
    .hw_standby    (hw_standby),
    .state         (state_mon)
);

// File: tb/standby_wake_ctrl_test.sv
module standby_wake_ctrl_test;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic       is_wake;
        logic [3:0] cause;
        int         len;
    } ev_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_stb = 1'b0, stby_sel = 1'b0;
    logic [2:0] settle_sel = '0;
    logic       nmi_req = 1'b0;
    logic [7:0] irq_req = '0, irq_en = '0, irq_mask = '0, irq_dma = '0;
    logic       res_n = 1'b1, mres_n = 1'b1, hwstby_n = 1'b1;
    logic       osc_en, clk_gate_en, bus_hiz, wake_irq_stb, reset_exc_stb, hw_standby;
    logic [3:0] wake_cause;

    int   n_checks = 0;
    int   n_err = 0;
    int   settle_cnt = 0;
    ev_t  exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    standby_wake_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sleep_stb(sleep_stb), .stby_sel(stby_sel),
        .settle_sel(settle_sel), .nmi_req(nmi_req), .irq_req(irq_req), .irq_en(irq_en),
        .irq_mask(irq_mask), .irq_dma(irq_dma), .res_n(res_n), .mres_n(mres_n),
        .hwstby_n(hwstby_n), .osc_en(osc_en), .clk_gate_en(clk_gate_en), .bus_hiz(bus_hiz),
        .wake_irq_stb(wake_irq_stb), .wake_cause(wake_cause), .reset_exc_stb(reset_exc_stb),
        .hw_standby(hw_standby)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: measures gated interval, pops expected events on each strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (osc_en && !clk_gate_en) settle_cnt++;
            if (wake_irq_stb || reset_exc_stb) begin
                if (exp_q.size() == 0) begin
                    chk("R4/R8 unexpected strobe", 32'(wake_irq_stb), 32'(0));
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    chk("R4/R8 event kind", 32'(wake_irq_stb), 32'(e.is_wake));
                    if (e.is_wake) chk("R6 wake cause", 32'(wake_cause), 32'(e.cause));
                    chk("R3 settle length", 32'(settle_cnt), 32'(e.len));
                end
                settle_cnt = 0;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sleep_pulse(input logic sel);
        stby_sel = sel;
        sleep_stb = 1'b1;
        tick(1);
        sleep_stb = 1'b0;
    endtask

    task automatic wait_event();
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (wake_irq_stb || reset_exc_stb) break;
        end
    endtask

    task automatic push(input logic w, input logic [3:0] c, input int l);
        ev_t e;
        e.is_wake = w; e.cause = c; e.len = l;
        exp_q.push_back(e);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        tick(3);
        @(negedge clk);
        chk("R11 osc_en in reset", 32'(osc_en), 1);
        chk("R11 clk_gate_en in reset", 32'(clk_gate_en), 1);
        chk("R11 bus_hiz in reset", 32'(bus_hiz), 0);
        chk("R11 strobes in reset", 32'({wake_irq_stb, reset_exc_stb, hw_standby}), 0);
        rst_n = 1'b1;
        tick(2);

        // R1: select bit clear keeps running
        sleep_pulse(1'b0);
        @(negedge clk);
        chk("R1 stays running gate", 32'(clk_gate_en), 1);
        chk("R1 stays running hiz", 32'(bus_hiz), 0);
        tick(1);

        // R1/R2: enter standby
        sleep_pulse(1'b1);
        @(negedge clk);
        chk("R1 standby osc_en", 32'(osc_en), 0);
        chk("R2 standby gate", 32'(clk_gate_en), 0);
        chk("R2 standby hiz", 32'(bus_hiz), 1);

        // R5: unqualified IRQ lines
        tick(1);
        irq_req = 8'h08; irq_en = 8'h00;
        tick(3); @(negedge clk);
        chk("R5 disabled irq no wake", 32'(osc_en), 0);
        irq_en = 8'h08; irq_mask = 8'h08;
        tick(3); @(negedge clk);
        chk("R5 masked irq no wake", 32'(osc_en), 0);
        irq_mask = 8'h00; irq_dma = 8'h08;
        tick(3); @(negedge clk);
        chk("R5 transfer irq no wake", 32'(osc_en), 0);
        chk("R2 no strobe in standby", 32'({wake_irq_stb, reset_exc_stb}), 0);
        tick(1);
        irq_req = 8'h00; irq_dma = 8'h00; irq_en = 8'h00;
        settle_cnt = 0;

        // R3/R4/R6: IRQ5 wake with code 0, sleep during settle (R10)
        settle_sel = 3'd0;
        irq_req = 8'h20; irq_en = 8'h20;
        push(1'b1, 4'd5, 256);
        tick(1);
        irq_req = 8'h00;
        @(negedge clk);
        chk("R3 osc restarts", 32'(osc_en), 1);
        chk("R3 clocks still gated", 32'(clk_gate_en), 0);
        tick(1);
        sleep_pulse(1'b1);
        wait_event();
        chk("R4 clocks return", 32'(clk_gate_en), 1);
        chk("R4 bus released", 32'(bus_hiz), 0);
        tick(3); @(negedge clk);
        chk("R10 sleep in settle ignored", 32'(clk_gate_en), 1);
        tick(1);

        // R6: NMI beats IRQ0, code 1
        sleep_pulse(1'b1);
        settle_sel = 3'd1;
        nmi_req = 1'b1; irq_req = 8'h01; irq_en = 8'h01;
        push(1'b1, 4'b1000, 512);
        tick(1);
        nmi_req = 1'b0; irq_req = 8'h00;
        wait_event();
        tick(2);

        // R6/R3: two IRQs, lowest index wins, longest code
        sleep_pulse(1'b1);
        settle_sel = 3'd7;
        irq_req = 8'h84; irq_en = 8'hFF;
        push(1'b1, 4'd2, 32768);
        tick(1);
        irq_req = 8'h00;
        wait_event();
        tick(2);

        // R7/R8: reset wake beats simultaneous NMI
        sleep_pulse(1'b1);
        tick(1);
        res_n = 1'b0; nmi_req = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R7 osc on reset", 32'(osc_en), 1);
        chk("R7 clocks on reset", 32'(clk_gate_en), 1);
        chk("R7 bus released on reset", 32'(bus_hiz), 0);
        tick(1);
        nmi_req = 1'b0;
        sleep_pulse(1'b1);
        tick(2); @(negedge clk);
        chk("R10 sleep in reset hold ignored", 32'({osc_en, clk_gate_en, bus_hiz}), 32'b110);
        tick(1);
        push(1'b0, 4'd0, 0);
        res_n = 1'b1;
        wait_event();
        tick(2);

        // R7/R8: manual reset path
        sleep_pulse(1'b1);
        tick(1);
        mres_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R7 manual reset clocks", 32'({osc_en, clk_gate_en}), 32'b11);
        tick(1);
        push(1'b0, 4'd0, 0);
        mres_n = 1'b1;
        wait_event();
        tick(2);

        // R9: hardware standby from running, sticky
        hwstby_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R9 hw standby flag", 32'(hw_standby), 1);
        chk("R9 hw standby outputs", 32'({osc_en, clk_gate_en, bus_hiz}), 32'b001);
        tick(1);
        hwstby_n = 1'b1; nmi_req = 1'b1; res_n = 1'b0;
        tick(4); @(negedge clk);
        chk("R9 hw standby held", 32'({hw_standby, osc_en}), 32'b10);
        nmi_req = 1'b0; res_n = 1'b1;
        rst_n = 1'b0;
        #1;
        chk("R11 reset leaves hw standby", 32'({hw_standby, clk_gate_en}), 32'b01);
        tick(1);
        rst_n = 1'b1;
        tick(2);

        chk("R4 all expected events seen", 32'(exp_q.size()), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule